// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the control logic behind the 8-bit conversion control register of a microcontroller's analog-to-digital converter. Software starts work by writing the register, either as a whole byte or one bit at a time. The block then issues conversion requests to a converter core over a start/channel/busy/done handshake. It raises an end-of-conversion interrupt flag and clears its own control bits when their work completes.

Three launch modes exist. A single conversion uses the channel held in the register. Continuous mode restarts the converter after every completion for as long as its bit stays set. List mode walks a table of channel codes in an external memory, one entry per conversion, and ends when it reads an in-band stop code. While list mode is armed but not yet walking the table, an address-latch permission output is held low. The interrupt controller's vector acknowledge clears the interrupt flag.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `adc_start`, `mem_rd_en` and `rsvd_chan` are low, and `ale_enable` is high.
- R2: Register layout: bit 7 interrupt flag, bit 6 list-mode enable, bit 5 continuous enable, bit 4 single start, bits 3:0 channel code. A byte write replaces all 8 bits. A bit write replaces only the bit numbered `bit_wr_idx`. If both arrive in one cycle the byte write wins. `reg_rd_data` always shows the current register.
- R3: A single conversion uses channel bits 3:0. In the cycle after `adc_done` is high, bit 4 reads 0 and bit 7 reads 1, and no further conversion follows.
- R4: A high `irq_ack` clears bit 7 at the next edge. Without an acknowledge or a software write, bit 7 keeps its value.
- R5: While bit 5 is set, a new conversion on channel bits 3:0 starts after each completion, and bit 7 is not set by these conversions. Once bit 5 is cleared, at most the conversion in progress completes and no new one starts.
- R6: A write that would set bit 4 while a conversion or list walk is in progress leaves bit 4 at 0.
- R7: In list mode, memory reads start at address 0 and advance by one per completed conversion. Read data arrives the cycle after `mem_rd_en`. Each conversion uses the 4-bit code read from memory, not bits 3:0.
- R8: A memory code of 15 ends the list: no conversion is started for it, bit 6 clears and bit 7 sets.
- R9: `ale_enable` is low while bit 6 is set and the list walk has not yet begun, and high while the list is being walked.
- R10: `rsvd_chan` is high for a conversion whose channel code is 13, 14 or 15, and low for codes 0 to 12. It holds its value until the next start.
- R11: `adc_start` is asserted only while `adc_busy` is low. When several modes are requested together, list mode runs first, then the single conversion, then continuous conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Byte write strobe |
| reg_wr_data | input | 8 | Byte write value |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_wr_idx | input | 3 | Bit number for a bit write |
| bit_wr_val | input | 1 | Value for a bit write |
| reg_rd_data | output | 8 | Current register contents |
| irq_flag | output | 1 | Interrupt flag (register bit 7) |
| irq_ack | input | 1 | Interrupt vector acknowledge |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 4 | Channel code for the requested conversion |
| adc_busy | input | 1 | Converter is converting |
| adc_done | input | 1 | One-cycle conversion-complete pulse |
| mem_rd_en | output | 1 | Channel list read strobe |
| mem_addr | output | ADDR_W | Channel list read address |
| mem_rd_data | input | 4 | Channel code, valid one cycle after the strobe |
| ale_enable | output | 1 | Address-latch permission |
| rsvd_chan | output | 1 | Last started conversion used a reserved code |

## Verification
A register write is visible on `reg_rd_data` one edge after its strobe. The matching `adc_start` follows one edge later. Completion effects on bits 4, 6 and 7 appear one edge after the cycle in which `adc_done` is high. A list entry read with `mem_rd_en` is acted on in the next cycle, and its `adc_start` comes one edge after that. The bench samples every output on the falling edge. It checks the interrupt flag both in the cycle `adc_done` is high (still clear) and in the next one (set). It logs every start and every memory read as it happens, so channel order, addresses and the reserved-code flag are compared against the expected sequence and not against a single snapshot.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int REG_W  = 8;
  localparam int CHAN_W = 4;
  localparam int IDX_W  = $clog2(REG_W);

  // bit positions within the control register
  localparam int B_IRQ  = 7;
  localparam int B_DMA  = 6;
  localparam int B_CONT = 5;
  localparam int B_SGL  = 4;

  localparam logic [CHAN_W-1:0] CH_STOP   = {CHAN_W{1'b1}};
  localparam logic [CHAN_W-1:0] CH_RSV_LO = CHAN_W'(13);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_FETCH = 3'd2,
    ST_CHECK = 3'd3,
    ST_DCONV = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic irq_set;
    logic sgl_clr;
    logic dma_clr;
  } hw_evt_t;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_we,
  input  logic [REG_W-1:0] byte_wdata,
  input  logic             bit_we,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_wval,
  input  logic             irq_ack,
  input  hw_evt_t          hw_evt,
  input  logic             conv_active,
  output logic [REG_W-1:0] ctrl_q
);
  logic [REG_W-1:0] sw_val;
  logic [REG_W-1:0] ctrl_d;
  logic             sw_we;
  logic             ctrl_en;

  always_comb begin
    sw_we  = byte_we | bit_we;
    sw_val = ctrl_q;
    if (byte_we) begin
      sw_val = byte_wdata;
    end else if (bit_we) begin
      sw_val[bit_idx] = bit_wval;
    end

    ctrl_d = ctrl_q;
    if (sw_we) begin
      ctrl_d = sw_val;
      // a new single request is refused while work is in progress
      if (conv_active && sw_val[B_SGL] && !ctrl_q[B_SGL]) begin
        ctrl_d[B_SGL] = 1'b0;
      end
    end
    if (irq_ack)        ctrl_d[B_IRQ] = 1'b0;
    if (hw_evt.sgl_clr) ctrl_d[B_SGL] = 1'b0;
    if (hw_evt.dma_clr) ctrl_d[B_DMA] = 1'b0;
    if (hw_evt.irq_set) ctrl_d[B_IRQ] = 1'b1;

    ctrl_en = sw_we | irq_ack | hw_evt.sgl_clr | hw_evt.dma_clr | hw_evt.irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sgl_go,
  input  logic              cont_en,
  input  logic              dma_en,
  input  logic [CHAN_W-1:0] reg_chan,
  input  logic              adc_busy,
  input  logic              adc_done,
  input  logic [CHAN_W-1:0] mem_rd_data,
  output seq_state_t        state_q,
  output logic              sgl_q,
  output logic              launch,
  output logic [CHAN_W-1:0] launch_chan,
  output hw_evt_t           hw_evt,
  output logic              addr_clr,
  output logic              addr_inc,
  output logic              mem_rd_en,
  output logic              dma_running,
  output logic              conv_active
);
  seq_state_t state_d;
  logic       sgl_d;

  always_comb begin
    state_d     = state_q;
    sgl_d       = sgl_q;
    launch      = 1'b0;
    launch_chan = reg_chan;
    hw_evt      = '0;
    addr_clr    = 1'b0;
    addr_inc    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (dma_en) begin
          state_d  = ST_FETCH;
          addr_clr = 1'b1;
        end else if ((sgl_go || cont_en) && !adc_busy) begin
          launch  = 1'b1;
          sgl_d   = sgl_go;
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        if (adc_done) begin
          state_d = ST_IDLE;
          if (sgl_q) begin
            hw_evt.sgl_clr = 1'b1;
            hw_evt.irq_set = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (mem_rd_data == CH_STOP) begin
          hw_evt.dma_clr = 1'b1;
          hw_evt.irq_set = 1'b1;
          state_d        = ST_IDLE;
        end else if (!adc_busy) begin
          launch      = 1'b1;
          launch_chan = mem_rd_data;
          state_d     = ST_DCONV;
        end else begin
          state_d = ST_FETCH;   // converter not free: read the entry again
        end
      end
      ST_DCONV: begin
        if (adc_done) begin
          addr_inc = 1'b1;
          state_d  = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_rd_en   = (state_q == ST_FETCH);
    dma_running = (state_q == ST_FETCH) || (state_q == ST_CHECK) || (state_q == ST_DCONV);
    conv_active = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sgl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        sgl_q <= sgl_d;
      end
    end
  end
endmodule

// File: rtl/adc_ctrl_addr.sv
module adc_ctrl_addr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = clr | inc;
    addr_d  = clr ? '0 : addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic              bit_wr_en,
  input  logic [IDX_W-1:0]  bit_wr_idx,
  input  logic              bit_wr_val,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              irq_flag,
  input  logic              irq_ack,
  output logic              adc_start,
  output logic [CHAN_W-1:0] adc_chan,
  input  logic              adc_busy,
  input  logic              adc_done,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [CHAN_W-1:0] mem_rd_data,
  output logic              ale_enable,
  output logic              rsvd_chan
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [REG_W-1:0]  ctrl_q;
  seq_state_t        state_q;
  logic              sgl_q;
  logic              launch;
  logic [CHAN_W-1:0] launch_chan;
  hw_evt_t           hw_evt;
  logic              addr_clr;
  logic              addr_inc;
  logic              dma_running;
  logic              conv_active;
  logic              start_q;
  logic [CHAN_W-1:0] chan_q;
  logic              rsvd_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  adc_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .byte_we    (reg_wr_en),
    .byte_wdata (reg_wr_data),
    .bit_we     (bit_wr_en),
    .bit_idx    (bit_wr_idx),
    .bit_wval   (bit_wr_val),
    .irq_ack    (irq_ack),
    .hw_evt     (hw_evt),
    .conv_active(conv_active),
    .ctrl_q     (ctrl_q)
  );

  adc_ctrl_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sgl_go     (ctrl_q[B_SGL]),
    .cont_en    (ctrl_q[B_CONT]),
    .dma_en     (ctrl_q[B_DMA]),
    .reg_chan   (ctrl_q[CHAN_W-1:0]),
    .adc_busy   (adc_busy),
    .adc_done   (adc_done),
    .mem_rd_data(mem_rd_data),
    .state_q    (state_q),
    .sgl_q      (sgl_q),
    .launch     (launch),
    .launch_chan(launch_chan),
    .hw_evt     (hw_evt),
    .addr_clr   (addr_clr),
    .addr_inc   (addr_inc),
    .mem_rd_en  (mem_rd_en),
    .dma_running(dma_running),
    .conv_active(conv_active)
  );

  adc_ctrl_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (addr_clr),
    .inc   (addr_inc),
    .addr_q(mem_addr)
  );

  // registered converter request
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      start_q <= 1'b0;
      chan_q  <= '0;
      rsvd_q  <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch) begin
        chan_q <= launch_chan;
        rsvd_q <= (launch_chan >= CH_RSV_LO);
      end
    end
  end

  assign adc_start   = start_q;
  assign adc_chan    = chan_q;
  assign rsvd_chan   = rsvd_q;
  assign reg_rd_data = ctrl_q;
  assign irq_flag    = ctrl_q[B_IRQ];
  assign ale_enable  = !(ctrl_q[B_DMA] && !dma_running);
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk
  import adc_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  ctrl_q,
  input seq_state_t        state_q,
  input logic              sgl_q,
  input logic              adc_start,
  input logic [CHAN_W-1:0] adc_chan,
  input logic              adc_busy,
  input logic              adc_done,
  input logic              irq_ack,
  input logic              byte_we,
  input logic [REG_W-1:0]  byte_wdata,
  input logic              bit_we,
  input logic              mem_rd_en,
  input logic              mem_addr_zero,
  input logic              dma_running,
  input logic              ale_enable,
  input logic              rsvd_chan
);
  assert_single_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && sgl_q && adc_done) |=> (!ctrl_q[B_SGL] && ctrl_q[B_IRQ]));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && state_q == ST_IDLE) |=> !ctrl_q[B_IRQ]);

  assert_irq_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_IRQ] && !irq_ack && !byte_we && !bit_we) |=> ctrl_q[B_IRQ]);

  assert_no_idle_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !ctrl_q[B_SGL] && !ctrl_q[B_CONT] && !ctrl_q[B_DMA]) |=> !adc_start);

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !ctrl_q[B_SGL] && byte_we && byte_wdata[B_SGL]) |=> !ctrl_q[B_SGL]);

  assert_list_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_running) |-> mem_addr_zero);

  assert_stop_not_started_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && dma_running) |-> (adc_chan != CH_STOP));

  assert_ale_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_DMA] && state_q == ST_IDLE) |-> !ale_enable);

  assert_ale_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ale_enable);

  assert_rsvd_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (rsvd_chan == (adc_chan >= CH_RSV_LO)));

  assert_start_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !adc_busy);
endmodule

bind adc_conv_ctrl adc_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .ctrl_q       (ctrl_q),
  .state_q      (state_q),
  .sgl_q        (sgl_q),
  .adc_start    (adc_start),
  .adc_chan     (adc_chan),
  .adc_busy     (adc_busy),
  .adc_done     (adc_done),
  .irq_ack      (irq_ack),
  .byte_we      (reg_wr_en),
  .byte_wdata   (reg_wr_data),
  .bit_we       (bit_wr_en),
  .mem_rd_en    (mem_rd_en),
  .mem_addr_zero(mem_addr == '0),
  .dma_running  (dma_running),
  .ale_enable   (ale_enable),
  .rsvd_chan    (rsvd_chan)
);

// File: tb/tb_adc_conv_ctrl.sv
module tb_adc_conv_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  ADDR_W     = 8;
  localparam int  LAT        = 6;
  localparam int  LOG_N      = 256;

  logic             clk;
  logic             rst_n;
  logic             reg_wr_en;
  logic [7:0]       reg_wr_data;
  logic             bit_wr_en;
  logic [2:0]       bit_wr_idx;
  logic             bit_wr_val;
  logic [7:0]       reg_rd_data;
  logic             irq_flag;
  logic             irq_ack;
  logic             adc_start;
  logic [3:0]       adc_chan;
  logic             adc_busy;
  logic             adc_done;
  logic             mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]       mem_rd_data;
  logic             ale_enable;
  logic             rsvd_chan;

  int n_chk;
  int n_err;
  bit finished;

  // activity logs filled on falling edges
  int         n_start;
  logic [3:0] start_chan [LOG_N];
  logic       start_rsvd [LOG_N];
  int         n_fetch;
  logic [ADDR_W-1:0] fetch_addr [LOG_N];
  int         busy_start_viol;
  int         ale_viol;

  logic [3:0] mem [16];
  int         cnt;

  adc_conv_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .bit_wr_en(bit_wr_en), .bit_wr_idx(bit_wr_idx), .bit_wr_val(bit_wr_val),
    .reg_rd_data(reg_rd_data), .irq_flag(irq_flag), .irq_ack(irq_ack),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_busy(adc_busy), .adc_done(adc_done),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .ale_enable(ale_enable), .rsvd_chan(rsvd_chan)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // converter model: busy for LAT cycles, then a one-cycle done pulse
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_busy <= 1'b0;
      adc_done <= 1'b0;
      cnt      <= 0;
    end else begin
      adc_done <= 1'b0;
      if (adc_busy) begin
        if (cnt == 1) begin
          adc_busy <= 1'b0;
          adc_done <= 1'b1;
        end
        cnt <= cnt - 1;
      end else if (adc_start) begin
        adc_busy <= 1'b1;
        cnt      <= LAT;
      end
    end
  end

  // channel list memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_addr[3:0]];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_start) begin
        if (n_start < LOG_N) begin
          start_chan[n_start] = adc_chan;
          start_rsvd[n_start] = rsvd_chan;
        end
        if (adc_busy) busy_start_viol++;
        n_start++;
      end
      if (mem_rd_en) begin
        if (n_fetch < LOG_N) fetch_addr[n_fetch] = mem_addr;
        if (!ale_enable) ale_viol++;
        n_fetch++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic wr_bit(input logic [2:0] idx, input logic v);
    @(negedge clk);
    bit_wr_en  = 1'b1;
    bit_wr_idx = idx;
    bit_wr_val = v;
    @(negedge clk);
    bit_wr_en  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(reg_rd_data == 8'h00, "R1 reg", reg_rd_data, 0);
    chk(!adc_start && !mem_rd_en && !rsvd_chan, "R1 outputs", {adc_start, mem_rd_en, rsvd_chan}, 0);
    chk(ale_enable, "R1 ale", ale_enable, 1);
  endtask

  task automatic t_rw();
    int base;
    base = n_start;
    wr_byte(8'h0A);
    chk(reg_rd_data == 8'h0A, "R2 byte write", reg_rd_data, 8'h0A);
    wr_bit(3'd3, 1'b0);
    chk(reg_rd_data == 8'h02, "R2 bit clear", reg_rd_data, 8'h02);
    wr_bit(3'd7, 1'b1);
    chk(reg_rd_data == 8'h82, "R2 bit set", reg_rd_data, 8'h82);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = 8'h01;
    bit_wr_en = 1'b1; bit_wr_idx = 3'd2; bit_wr_val = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; bit_wr_en = 1'b0;
    chk(reg_rd_data == 8'h01, "R2 byte wins", reg_rd_data, 8'h01);
    idle(4);
    chk(n_start == base, "R2 no start", n_start - base, 0);
  endtask

  task automatic t_single();
    int base;
    int to;
    base = n_start;
    wr_byte(8'h15);
    to = 0;
    while (!adc_done && to < 100) begin @(negedge clk); to++; end
    chk(!reg_rd_data[7] && reg_rd_data[4], "R3 before done edge", reg_rd_data, 8'h15);
    @(negedge clk);
    chk(reg_rd_data == 8'h85, "R3 after done", reg_rd_data, 8'h85);
    chk(n_start == base + 1 && start_chan[base] == 4'd5, "R3 channel", start_chan[base], 5);
    idle(20);
    chk(n_start == base + 1, "R3 no repeat", n_start - base, 1);
    chk(irq_flag, "R4 flag holds", irq_flag, 1);
  endtask

  task automatic t_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(!irq_flag, "R4 ack clears", irq_flag, 0);
    wr_bit(3'd7, 1'b1);
    idle(3);
    chk(irq_flag, "R4 sw set holds", irq_flag, 1);
    wr_bit(3'd7, 1'b0);
    chk(!irq_flag, "R4 sw clear", irq_flag, 0);
  endtask

  task automatic t_cont();
    int base;
    int snap;
    int to;
    base = n_start;
    wr_byte(8'h23);
    to = 0;
    while (n_start < base + 3 && to < 200) begin @(negedge clk); to++; end
    chk(n_start >= base + 3, "R5 restarts", n_start - base, 3);
    chk(start_chan[base] == 4'd3 && start_chan[base+1] == 4'd3 && start_chan[base+2] == 4'd3,
        "R5 channel", start_chan[base+2], 3);
    chk(!irq_flag, "R5 no irq", irq_flag, 0);
    wr_bit(3'd5, 1'b0);
    snap = n_start;
    idle(30);
    chk(n_start <= snap + 1, "R5 stop after clear", n_start - snap, 1);
    snap = n_start;
    idle(30);
    chk(n_start == snap && !adc_busy, "R5 stays stopped", n_start - snap, 0);
  endtask

  task automatic t_busy_ignore();
    int to;
    wr_byte(8'h21);
    to = 0;
    while (!adc_busy && to < 50) begin @(negedge clk); to++; end
    wr_byte(8'h31);
    chk(!reg_rd_data[4], "R6 byte ignored", reg_rd_data[4], 0);
    wr_bit(3'd4, 1'b1);
    chk(!reg_rd_data[4], "R6 bit ignored", reg_rd_data[4], 0);
    wr_bit(3'd5, 1'b0);
    idle(30);
    chk(!irq_flag && !reg_rd_data[4], "R6 no single ran", irq_flag, 0);
  endtask

  task automatic t_dma();
    int base;
    int fbase;
    int to;
    mem[0] = 4'd2; mem[1] = 4'd13; mem[2] = 4'd5; mem[3] = 4'd15;
    base  = n_start;
    fbase = n_fetch;
    wr_byte(8'h47);
    chk(!ale_enable, "R9 ale held", ale_enable, 0);
    to = 0;
    while (reg_rd_data[6] && to < 300) begin @(negedge clk); to++; end
    chk(n_start == base + 3, "R7 start count", n_start - base, 3);
    chk(start_chan[base] == 4'd2 && start_chan[base+1] == 4'd13 && start_chan[base+2] == 4'd5,
        "R7 channels from memory", start_chan[base+1], 13);
    chk(n_fetch == fbase + 4, "R7 fetch count", n_fetch - fbase, 4);
    chk(fetch_addr[fbase] == 0 && fetch_addr[fbase+1] == 1 && fetch_addr[fbase+2] == 2
        && fetch_addr[fbase+3] == 3, "R7 addresses", fetch_addr[fbase+3], 3);
    chk(!start_rsvd[base] && start_rsvd[base+1] && !start_rsvd[base+2],
        "R10 list codes", start_rsvd[base+1], 1);
    chk(irq_flag && !reg_rd_data[6], "R8 end of list", reg_rd_data, 8'h87);
    chk(ale_enable && ale_viol == 0, "R9 ale while walking", ale_viol, 0);
  endtask

  task automatic t_dma_stop_first();
    int base;
    int fbase;
    int to;
    wr_byte(8'h00);
    mem[0] = 4'd15;
    base  = n_start;
    fbase = n_fetch;
    wr_byte(8'h40);
    to = 0;
    while (reg_rd_data[6] && to < 100) begin @(negedge clk); to++; end
    chk(n_start == base && n_fetch == fbase + 1, "R8 stop code first", n_start - base, 0);
    chk(irq_flag, "R8 irq on stop", irq_flag, 1);
  endtask

  task automatic t_prio();
    int base;
    int to;
    wr_byte(8'h00);
    mem[0] = 4'd9; mem[1] = 4'd15;
    base = n_start;
    wr_byte(8'h52);
    to = 0;
    while ((reg_rd_data[4] || reg_rd_data[6]) && to < 300) begin @(negedge clk); to++; end
    chk(n_start == base + 2, "R11 count", n_start - base, 2);
    chk(start_chan[base] == 4'd9 && start_chan[base+1] == 4'd2, "R11 list before single",
        start_chan[base], 9);
  endtask

  task automatic t_reserved();
    int base;
    int to;
    wr_byte(8'h00);
    base = n_start;
    wr_byte(8'h1E);
    to = 0;
    while (reg_rd_data[4] && to < 100) begin @(negedge clk); to++; end
    chk(start_rsvd[base] && rsvd_chan, "R10 code 14", rsvd_chan, 1);
    wr_byte(8'h14);
    to = 0;
    while (reg_rd_data[4] && to < 100) begin @(negedge clk); to++; end
    chk(!start_rsvd[base+1] && !rsvd_chan, "R10 code 4", rsvd_chan, 0);
    chk(busy_start_viol == 0, "R11 start while busy", busy_start_viol, 0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; finished = 1'b0;
    n_start = 0; n_fetch = 0; busy_start_viol = 0; ale_viol = 0;
    for (int i = 0; i < 16; i++) mem[i] = 4'd15;
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wr_data = 8'h00;
    bit_wr_en = 1'b0; bit_wr_idx = 3'd0; bit_wr_val = 1'b0;
    irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_rw();
    t_single();
    t_ack();
    t_cont();
    t_busy_ignore();
    t_dma();
    t_dma_stop_first();
    t_prio();
    t_reserved();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule